// File: doc/BRIEF.md
# Serial Bus Frame-Symbol Timer and Transmit Gate

This block sits behind the line receiver of a single-wire serial vehicle network (J1850 class). The bus level reaches it already reduced to active and passive. The block measures the length of every passive stretch and turns it into the symbols that frame a message. These are end of data, end of frame, the inter-frame separation, and the idle bus that follows. From those symbols it decides when a transmitter waiting to send may launch its start-of-frame.

A second node can begin its start-of-frame while this node is still waiting out the separation time, because node clocks differ. When that happens the block restarts its timing from the rising edge of that node's start-of-frame. A request that arrives soon enough after the edge is still allowed to start and arbitrate. A request that arrives later is held back until the next separation period ends.

Any bytes of an in-frame response are masked from the receiver until end of frame, and this node never sends a response of its own. An over-long active period is treated as a break. If this node is transmitting, the break is reported as lost arbitration. If it is receiving, the break is reported as a receive error with a flush pulse. After a break the block does not report an idle bus until a full end-of-frame time and then the separation time have passed.

Top module: `bus_symbol_gate`

## Requirements
- R1: While reset is held, and on the first cycle after release, every output is low. `busIdle` stays low until the bus has been passive for the separation time.
- R2: `busIn` is 1 for active and 0 for passive. When a frame this node sends or receives turns passive, `eodPulse` is high for exactly one cycle, EOD_TICKS+3 cycles after `busIn` fell (two synchroniser stages, the count, and an output register).
- R3: In the same passive stretch, `eofPulse` fires once, EOF_TICKS+3 cycles after `busIn` fell. During one passive stretch each symbol pulse fires at most once.
- R4: In the same passive stretch, `sepPulse` fires once, SEP_TICKS+3 cycles after `busIn` fell. `busIdle` rises in that same cycle and stays high while the bus remains passive and nothing is sent.
- R5: A one-cycle `txReq` while `busIdle` is high produces a one-cycle `txStart` on the next cycle, and `busIdle` drops in that same cycle.
- R6: A request that arrives between end of data and the end of separation is held. `txStart` then fires one cycle after `sepPulse`, and never earlier.
- R7: While the block waits out separation, suppose `busIn` goes active at cycle t. A request in cycle t+2+d with d ≤ RESYNC_TICKS (104) produces `txStart` on the next cycle. With d = RESYNC_TICKS+1 no `txStart` occurs until one cycle after the next `sepPulse`.
- R8: After end of data, bus activity or a high `ifrActive` raises `rxMute` until end of frame. That response produces no `eodPulse`, and a request made during it starts only after the following separation.
- R9: While transmitting, an active period of BRK_TICKS raises `arbLost` for one cycle, BRK_TICKS+3 cycles after `busIn` rose. `brkFlag` rises with it, and `rxFlush` stays low.
- R10: While receiving, the same break raises `rxFlush` for one cycle at BRK_TICKS+3, and `arbLost` stays low.
- R11: After a break, the next passive stretch produces no `eodPulse`. It produces `eofPulse` at EOF_TICKS+3 and then `sepPulse` and `busIdle` at SEP_TICKS+3, and `brkFlag` has fallen by then.
- R12: In any cycle at most one of `eodPulse`, `eofPulse`, `sepPulse`, `txStart`, `arbLost` and `rxFlush` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; one tick per cycle |
| rstN | input | 1 | Active-low asynchronous reset |
| busIn | input | 1 | Decoded bus level, 1 = active |
| txReq | input | 1 | One-cycle request to send a frame |
| ifrActive | input | 1 | Receiver reports an in-frame response in progress |
| eodPulse | output | 1 | End-of-data symbol detected |
| eofPulse | output | 1 | End-of-frame symbol detected |
| sepPulse | output | 1 | Separation time expired |
| txStart | output | 1 | Transmitter may launch start-of-frame |
| arbLost | output | 1 | Break seen while transmitting |
| brkFlag | output | 1 | Break in progress, held until end of frame |
| rxFlush | output | 1 | Break seen while receiving; discard partial message |
| rxMute | output | 1 | Receive suppressed during an in-frame response |
| busIdle | output | 1 | Bus idle, a start-of-frame may begin at once |

## Verification
The assertions check on every cycle the properties that do not depend on a scenario. No two event pulses coincide. Each pulse lasts one cycle. The idle flag only follows a passive sample. No start is issued while a response is muted. Lost arbitration always comes with the break flag. The level counter restarts on every bus edge.

Only the bench's scenarios can show the exact symbol latencies. They also show the boundary of the resynchronisation window between tick 104 and tick 105, the deferral of requests to the next separation, the silencing of a response, and the recovery after a break.

// File: rtl/sym_gate_pkg.sv
package sym_gate_pkg;

  typedef enum logic [2:0] {
    ST_WAITSEP,
    ST_IDLE,
    ST_TX,
    ST_RX,
    ST_POSTEOD,
    ST_RESP,
    ST_BREAK
  } frameState_t;

  // strobes from the timing datapath to the control
  typedef struct packed {
    logic level;     // synchronised bus level
    logic edgeSeen;  // level differs from previous sample
    logic riseSeen;  // passive to active
    logic hitEod;    // passive run reached end-of-data length
    logic hitEof;    // passive run reached end-of-frame length
    logic hitSep;    // passive run reached separation length
    logic hitBrk;    // active run reached break length
    logic winOpen;   // within resync window after last rise
  } busStat_t;

endpackage

// File: rtl/sym_gate_sync.sv
module sym_gate_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[g] <= 1'b0;
          else       chain[g] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[g] <= 1'b0;
          else       chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/sym_gate_dp.sv
module sym_gate_dp
  import sym_gate_pkg::*;
#(
  parameter int EOD_TICKS    = 163,
  parameter int EOF_TICKS    = 239,
  parameter int SEP_TICKS    = 280,
  parameter int BRK_TICKS    = 239,
  parameter int RESYNC_TICKS = 104,
  parameter int SYNC_STAGES  = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     busIn,
  output busStat_t stat
);

  localparam int LONGEST = (SEP_TICKS > BRK_TICKS) ? SEP_TICKS : BRK_TICKS;
  localparam int CNT_MAX = LONGEST + 1;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam int WIN_MAX = RESYNC_TICKS + 1;
  localparam int WW      = $clog2(WIN_MAX + 1);

  logic          busS;
  logic          busPrev;
  logic [CW-1:0] runCnt;
  logic [WW-1:0] winCnt;
  logic          edgeNow;
  logic          riseNow;

  sym_gate_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  (busIn),
    .dout (busS)
  );

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) busPrev <= 1'b0;
    else       busPrev <= busS;

  assign edgeNow = busS ^ busPrev;
  assign riseNow = busS & ~busPrev;

  // length of the current level, restarted by every edge, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         runCnt <= '0;
    else if (edgeNow)                  runCnt <= CW'(1);
    else if (runCnt != CW'(CNT_MAX))   runCnt <= runCnt + CW'(1);
  end

  // ticks since the last rising edge, parked just past the window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         winCnt <= WW'(WIN_MAX);
    else if (riseNow)                  winCnt <= WW'(1);
    else if (winCnt != WW'(WIN_MAX))   winCnt <= winCnt + WW'(1);
  end

  always_comb begin
    stat.level    = busS;
    stat.edgeSeen = edgeNow;
    stat.riseSeen = riseNow;
    stat.hitEod   = ~busS & ~edgeNow & (runCnt == CW'(EOD_TICKS));
    stat.hitEof   = ~busS & ~edgeNow & (runCnt == CW'(EOF_TICKS));
    stat.hitSep   = ~busS & ~edgeNow & (runCnt == CW'(SEP_TICKS));
    stat.hitBrk   =  busS & ~edgeNow & (runCnt == CW'(BRK_TICKS));
    stat.winOpen  = (winCnt <= WW'(RESYNC_TICKS));
  end

  // R3: every edge of the bus restarts the run length
  p_cnt_restart_r3: assert property (@(posedge clk) disable iff (!rstN)
    edgeNow |=> (runCnt == CW'(1)));

  // R7: a rising edge always opens a fresh resync window
  p_win_opens_r7: assert property (@(posedge clk) disable iff (!rstN)
    riseNow |=> stat.winOpen);

endmodule

// File: rtl/sym_gate_ctl.sv
module sym_gate_ctl
  import sym_gate_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  busStat_t stat,
  input  logic     txReq,
  input  logic     ifrActive,
  output logic     eodPulse,
  output logic     eofPulse,
  output logic     sepPulse,
  output logic     txStart,
  output logic     arbLost,
  output logic     brkFlag,
  output logic     rxFlush,
  output logic     rxMute,
  output logic     busIdle
);

  frameState_t state, nState;
  logic pend, nPend;
  logic winArm, nWin;
  logic doEod, doEof, doSep, doStart, doArb, doFlush;

  always_comb begin
    nState  = state;
    nPend   = pend | txReq;
    nWin    = winArm & stat.winOpen;
    doEod   = 1'b0;
    doEof   = 1'b0;
    doSep   = 1'b0;
    doStart = 1'b0;
    doArb   = 1'b0;
    doFlush = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (pend | txReq) begin
          doStart = 1'b1;
          nPend   = 1'b0;
          nState  = ST_TX;
        end else if (stat.riseSeen) begin
          nState  = ST_RX;
        end
      end
      ST_WAITSEP: begin
        if (stat.riseSeen) begin
          if (pend | txReq) begin
            doStart = 1'b1;
            nPend   = 1'b0;
            nState  = ST_TX;
          end else begin
            nWin    = 1'b1;
            nState  = ST_RX;
          end
        end else if (stat.hitSep) begin
          doSep  = 1'b1;
          nState = ST_IDLE;
        end
      end
      ST_TX: begin
        if (stat.hitBrk) begin
          doArb  = 1'b1;
          nState = ST_BREAK;
        end else if (stat.hitEod) begin
          doEod  = 1'b1;
          nState = ST_POSTEOD;
        end
      end
      ST_RX: begin
        if (stat.hitBrk) begin
          doFlush = 1'b1;
          nWin    = 1'b0;
          nState  = ST_BREAK;
        end else if (winArm && stat.winOpen && txReq) begin
          doStart = 1'b1;
          nPend   = 1'b0;
          nWin    = 1'b0;
          nState  = ST_TX;
        end else if (stat.hitEod) begin
          doEod   = 1'b1;
          nWin    = 1'b0;
          nState  = ST_POSTEOD;
        end
      end
      ST_POSTEOD: begin
        if (stat.riseSeen || ifrActive) begin
          nState = ST_RESP;
        end else if (stat.hitEof) begin
          doEof  = 1'b1;
          nState = ST_WAITSEP;
        end
      end
      ST_RESP: begin
        if (stat.hitBrk) begin
          doFlush = 1'b1;
          nState  = ST_BREAK;
        end else if (stat.hitEof) begin
          doEof  = 1'b1;
          nState = ST_WAITSEP;
        end
      end
      ST_BREAK: begin
        if (stat.hitEof) begin
          doEof  = 1'b1;
          nState = ST_WAITSEP;
        end
      end
      default: nState = ST_WAITSEP;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_WAITSEP;
      pend     <= 1'b0;
      winArm   <= 1'b0;
      eodPulse <= 1'b0;
      eofPulse <= 1'b0;
      sepPulse <= 1'b0;
      txStart  <= 1'b0;
      arbLost  <= 1'b0;
      rxFlush  <= 1'b0;
      brkFlag  <= 1'b0;
      rxMute   <= 1'b0;
      busIdle  <= 1'b0;
    end else begin
      state    <= nState;
      pend     <= nPend;
      winArm   <= nWin;
      eodPulse <= doEod;
      eofPulse <= doEof;
      sepPulse <= doSep;
      txStart  <= doStart;
      arbLost  <= doArb;
      rxFlush  <= doFlush;
      brkFlag  <= (nState == ST_BREAK);
      rxMute   <= (nState == ST_RESP);
      busIdle  <= (nState == ST_IDLE);
    end
  end

  // R12: event pulses never overlap
  p_one_event_r12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({eodPulse, eofPulse, sepPulse, txStart, arbLost, rxFlush}));

  // R2: end-of-data pulse lasts a single cycle
  p_eod_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    eodPulse |=> !eodPulse);

  // R4: idle is only reported after a passive sample
  p_idle_passive_r4: assert property (@(posedge clk) disable iff (!rstN)
    busIdle |-> !$past(stat.level));

  // R8: no start while a response is being masked
  p_no_resp_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    txStart |-> !$past(rxMute));

  // R9: lost arbitration always comes with the break flag
  p_arb_brk_r9: assert property (@(posedge clk) disable iff (!rstN)
    arbLost |-> brkFlag);

endmodule

// File: rtl/bus_symbol_gate.sv
module bus_symbol_gate
  import sym_gate_pkg::*;
#(
  parameter int EOD_TICKS    = 163,
  parameter int EOF_TICKS    = 239,
  parameter int SEP_TICKS    = 280,
  parameter int BRK_TICKS    = 239,
  parameter int RESYNC_TICKS = 104,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic busIn,
  input  logic txReq,
  input  logic ifrActive,
  output logic eodPulse,
  output logic eofPulse,
  output logic sepPulse,
  output logic txStart,
  output logic arbLost,
  output logic brkFlag,
  output logic rxFlush,
  output logic rxMute,
  output logic busIdle
);

  busStat_t stat;

  sym_gate_dp #(
    .EOD_TICKS    (EOD_TICKS),
    .EOF_TICKS    (EOF_TICKS),
    .SEP_TICKS    (SEP_TICKS),
    .BRK_TICKS    (BRK_TICKS),
    .RESYNC_TICKS (RESYNC_TICKS),
    .SYNC_STAGES  (SYNC_STAGES)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .busIn (busIn),
    .stat  (stat)
  );

  sym_gate_ctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .stat      (stat),
    .txReq     (txReq),
    .ifrActive (ifrActive),
    .eodPulse  (eodPulse),
    .eofPulse  (eofPulse),
    .sepPulse  (sepPulse),
    .txStart   (txStart),
    .arbLost   (arbLost),
    .brkFlag   (brkFlag),
    .rxFlush   (rxFlush),
    .rxMute    (rxMute),
    .busIdle   (busIdle)
  );

endmodule

// File: tb/sim_bus_symbol_gate.sv
`timescale 1ns/1ps
module sim_bus_symbol_gate;

  localparam int EODT = 163;
  localparam int EOFT = 239;
  localparam int SEPT = 280;
  localparam int BRKT = 239;
  localparam int WINT = 104;
  localparam int LAT  = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busIn = 1'b0;
  logic txReq = 1'b0;
  logic ifrActive = 1'b0;
  logic eodPulse, eofPulse, sepPulse, txStart, arbLost, brkFlag, rxFlush, rxMute, busIdle;

  int nChk = 0;
  int nBad = 0;
  int tE, tF, tI, tS, nE, nF, nI, nS, nA, nX;

  always #2.5 clk = ~clk;

  bus_symbol_gate u0 (
    .clk(clk), .rstN(rstN), .busIn(busIn), .txReq(txReq), .ifrActive(ifrActive),
    .eodPulse(eodPulse), .eofPulse(eofPulse), .sepPulse(sepPulse), .txStart(txStart),
    .arbLost(arbLost), .brkFlag(brkFlag), .rxFlush(rxFlush), .rxMute(rxMute),
    .busIdle(busIdle)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic hold(input logic lvl, input int n);
    busIn = lvl;
    repeat (n) @(negedge clk);
  endtask

  // drive passive for len cycles, record first cycle and count of each event
  task automatic passWatch(input int len, input int reqAt);
    tE = 0; tF = 0; tI = 0; tS = 0;
    nE = 0; nF = 0; nI = 0; nS = 0; nA = 0; nX = 0;
    busIn = 1'b0;
    for (int i = 1; i <= len; i++) begin
      @(negedge clk);
      if (eodPulse) begin nE++; if (tE == 0) tE = i; end
      if (eofPulse) begin nF++; if (tF == 0) tF = i; end
      if (sepPulse) begin nI++; if (tI == 0) tI = i; end
      if (txStart)  begin nS++; if (tS == 0) tS = i; end
      if (arbLost)  nA++;
      if (rxFlush)  nX++;
      txReq = (i == reqAt);
    end
    txReq = 1'b0;
  endtask

  task automatic finishFrame();
    hold(1'b1, 80);
    passWatch(300, 0);
    chk("R4 idle after frame", tI, SEPT + LAT);
  endtask

  task automatic tReset();
    chk("R1 idle in reset", busIdle, 0);
    chk("R1 pulses in reset", {eodPulse, eofPulse, sepPulse, txStart, arbLost, rxFlush}, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", busIdle, 0);
    chk("R1 flags after release", {brkFlag, rxMute, txStart}, 0);
    for (int i = 0; i < 400 && !busIdle; i++) @(negedge clk);
    chk("R1 idle reached after separation", busIdle, 1);
  endtask

  task automatic tIdleStart();
    txReq = 1'b1;
    @(negedge clk);
    txReq = 1'b0;
    chk("R5 txStart next cycle", txStart, 1);
    chk("R5 idle drops", busIdle, 0);
    @(negedge clk);
    chk("R5 txStart one cycle", txStart, 0);
    hold(1'b1, 150);
    hold(1'b0, 30);
    hold(1'b1, 60);
    passWatch(300, 0);
    chk("R2 eod latency", tE, EODT + LAT);
    chk("R3 eof latency", tF, EOFT + LAT);
    chk("R4 sep latency", tI, SEPT + LAT);
    chk("R3 one pulse each", nE * 100 + nF * 10 + nI, 111);
    chk("R4 idle held", busIdle, 1);
  endtask

  task automatic tDefer();
    hold(1'b1, 100);
    hold(1'b0, 20);
    hold(1'b1, 50);
    passWatch(300, 200);
    chk("R2 eod in rx", tE, EODT + LAT);
    chk("R6 deferred start", tS, SEPT + LAT + 1);
    chk("R6 single start", nS, 1);
    finishFrame();
  endtask

  task automatic tResp();
    hold(1'b1, 100);
    passWatch(180, 0);
    chk("R2 eod before response", tE, EODT + LAT);
    ifrActive = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R8 mute on ifrActive", rxMute, 1);
    ifrActive = 1'b0;
    busIn = 1'b1;
    repeat (30) @(negedge clk);
    chk("R8 mute during response", rxMute, 1);
    txReq = 1'b1;
    @(negedge clk);
    txReq = 1'b0;
    chk("R8 no start in response", txStart, 0);
    hold(1'b1, 29);
    hold(1'b0, 20);
    hold(1'b1, 40);
    passWatch(300, 0);
    chk("R8 no eod from response", nE, 0);
    chk("R8 eof after response", tF, EOFT + LAT);
    chk("R8 start after separation", tS, SEPT + LAT + 1);
    chk("R8 mute released", rxMute, 0);
    finishFrame();
  endtask

  task automatic tResync(input int d, input bit grant);
    hold(1'b1, 100);
    passWatch(260, 0);
    chk("R7 eof before resync", tF, EOFT + LAT);
    chk("R7 still separating", nI, 0);
    busIn = 1'b1;
    repeat (2 + d) @(negedge clk);
    txReq = 1'b1;
    @(negedge clk);
    txReq = 1'b0;
    chk(grant ? "R7 start inside window" : "R7 no start after window", txStart, grant ? 1 : 0);
    hold(1'b1, 40);
    passWatch(320, 0);
    chk("R7 sep after resync frame", tI, SEPT + LAT);
    if (grant) chk("R7 no extra start", nS, 0);
    else begin
      chk("R7 deferred to next separation", tS, SEPT + LAT + 1);
      finishFrame();
    end
  endtask

  task automatic tBreak(input bit sending);
    int tHit, nOther;
    tHit = 0; nOther = 0;
    if (sending) begin
      txReq = 1'b1;
      @(negedge clk);
      txReq = 1'b0;
    end
    busIn = 1'b1;
    for (int i = 1; i <= 300; i++) begin
      @(negedge clk);
      if ((sending ? arbLost : rxFlush) && tHit == 0) begin
        tHit = i;
        chk("R9 brkFlag with break", brkFlag, 1);
      end
      if (sending ? rxFlush : arbLost) nOther++;
    end
    chk(sending ? "R9 arbLost latency" : "R10 rxFlush latency", tHit, BRKT + LAT);
    chk(sending ? "R9 no rxFlush" : "R10 no arbLost", nOther, 0);
    passWatch(320, 0);
    chk("R11 no eod after break", nE, 0);
    chk("R11 eof after break", tF, EOFT + LAT);
    chk("R11 idle after break", tI, SEPT + LAT);
    chk("R11 brkFlag cleared", brkFlag, 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog (all): got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    tReset();
    tIdleStart();
    tDefer();
    tResp();
    tResync(WINT, 1'b1);
    tResync(WINT + 1, 1'b0);
    tBreak(1'b1);
    tBreak(1'b0);
    summary();
    $finish;
  end

endmodule